// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a 32-lane scratchpad. A request group carries one byte address per lane, write data per lane, a per-lane active mask and one read/write flag for the whole group. The storage is split into 32 banks of 32-bit words. Lanes whose addresses fall in different banks are all served in the same cycle. Lanes that hit one bank at different words are served over successive cycles. Lanes that hit the very same word share one access.

Once a group is taken, the block stays busy until every active lane has been served. It then pulses done for one cycle and reports the conflict degree, which is the number of service cycles the group needed. The degree tells software how well its access pattern was spread over the banks. A stride of 1, 2, 4, 8 or 32 words costs 1, 2, 4, 8 or 32 cycles.

Top module: `spad_banked`

## Requirements
- R1: Bits [1:0] of a lane's byte address are ignored, bits [6:2] select the bank and bits [11:7] select the word row inside the bank. An active group whose lanes all target distinct banks completes with degree 1.
- R2: The degree equals the largest count of distinct words requested from any single bank. Word strides of 1, 2, 4, 8 and 32 give degrees 1, 2, 4, 8 and 32. At least one pending lane is retired every busy cycle.
- R3: Lanes that read the same word do not conflict: they all receive that word in the same cycle (broadcast).
- R4: When several lanes of a write group name the same word, the data of the highest-numbered active lane is stored.
- R5: Lanes whose mask bit is 0 take no bank slot, do not write, and return zero read data.
- R6: A group is taken at a rising edge where req_valid is 1 and busy is 0. Busy is then high for exactly degree cycles. Done is high for one cycle, in the cycle after busy falls, together with the new degree. Read data and degree are valid at done and are held until the next group is taken and the next group completes, respectively.
- R7: While busy is high, req_valid is ignored: the running group's result is unchanged, no second group starts, and nothing is written.
- R8: After reset, busy and done are 0, degree is 0 and all read data is 0.
- R9: A read returns the value most recently written to that word.
- R10: A group with an all-zero mask completes after one busy cycle, with degree 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Offer a request group |
| req_write | input | 1 | 1 = write group, 0 = read group |
| req_mask | input | 32 | Active lane mask, bit n for lane n |
| req_addr | input | 384 | Lane byte addresses, 12 bits per lane, lane n at [12n+11:12n] |
| req_wdata | input | 1024 | Lane write data, 32 bits per lane, lane n at [32n+31:32n] |
| busy | output | 1 | Group in service; new groups refused |
| done | output | 1 | One-cycle pulse after the last lane is served |
| degree | output | 6 | Service cycles taken by the last completed group |
| rsp_rdata | output | 1024 | Per-lane read data, same layout as req_wdata |

## Verification
A wrong pending set inside the block shows at the ports as a busy window that is too long or too short, and so as a wrong degree on the done cycle. A wrong choice of the served word shows as wrong read data for the lanes of that bank in the same group. A corrupted write shows only when the affected word is read back, so the bench reads back every region that a write or a refused request could have touched. The reference model predicts busy and done on every clock of each group, so a timing slip is reported in the cycle where it happens.

// File: rtl/spad_pkg.sv
package spad_pkg;
  parameter int SPAD_LANES  = 32;
  parameter int SPAD_BANKS  = 32;
  parameter int SPAD_DEPTH  = 32;
  parameter int SPAD_DATA_W = 32;
endpackage

// File: rtl/spad_bank_arb.sv
module spad_bank_arb #(
  parameter int LANES   = 32,
  parameter int BANK_W  = 5,
  parameter int WORD_W  = 5,
  parameter int DATA_W  = 32,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]             pending,
  input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
  input  logic [LANES-1:0][WORD_W-1:0] lane_word,
  input  logic [LANES-1:0][DATA_W-1:0] lane_wdata,
  output logic [LANES-1:0]             served,
  output logic                         any,
  output logic [WORD_W-1:0]            sel_word,
  output logic [DATA_W-1:0]            sel_wdata
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  logic [LANES-1:0] hit;

  // lowest pending lane of this bank picks the word; sharers ride along
  always_comb begin
    any      = 1'b0;
    sel_word = '0;
    for (int l = 0; l < LANES; l++) begin
      hit[l] = pending[l] && (lane_bank[l] == MY_BANK);
      if (hit[l] && !any) begin
        sel_word = lane_word[l];
        any      = 1'b1;
      end
    end
  end

  // highest served lane provides the stored data
  always_comb begin
    sel_wdata = '0;
    for (int l = 0; l < LANES; l++) begin
      served[l] = hit[l] && (lane_word[l] == sel_word);
      if (served[l]) sel_wdata = lane_wdata[l];
    end
  end
endmodule

// File: rtl/spad_bank_mem.sv
module spad_bank_mem #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/spad_banked.sv
module spad_banked
  import spad_pkg::*;
#(
  parameter int LANES  = SPAD_LANES,
  parameter int BANKS  = SPAD_BANKS,
  parameter int DEPTH  = SPAD_DEPTH,
  parameter int DATA_W = SPAD_DATA_W,
  localparam int BANK_W = $clog2(BANKS),
  localparam int WORD_W = $clog2(DEPTH),
  localparam int OFF_W  = $clog2(DATA_W/8),
  localparam int ADDR_W = OFF_W + BANK_W + WORD_W,
  localparam int CNT_W  = $clog2(LANES+1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [LANES-1:0]         req_mask,
  input  logic [LANES*ADDR_W-1:0]  req_addr,
  input  logic [LANES*DATA_W-1:0]  req_wdata,
  output logic                     busy,
  output logic                     done,
  output logic [CNT_W-1:0]         degree,
  output logic [LANES*DATA_W-1:0]  rsp_rdata
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // state
  logic                         busy_q, busy_d, done_q, done_d, write_q;
  logic [LANES-1:0]             pend_q, pend_d;
  logic [CNT_W-1:0]             cnt_q, cnt_d, deg_q, deg_d;
  logic [LANES-1:0][DATA_W-1:0] rdat_q, rdat_d;
  logic [LANES-1:0][BANK_W-1:0] bank_q, bank_d;
  logic [LANES-1:0][WORD_W-1:0] word_q, word_d;
  logic [LANES-1:0][DATA_W-1:0] wdat_q, wdat_d;
  logic [LANES-1:0][OFF_W-1:0]  unused_off;

  // per-bank results
  logic [BANKS-1:0][LANES-1:0]  served_bk;
  logic [BANKS-1:0]             any_bk;
  logic [BANKS-1:0][WORD_W-1:0] selw_bk;
  logic [BANKS-1:0][DATA_W-1:0] seld_bk, rd_bk;
  logic [LANES-1:0]             served_all, remain;
  logic [LANES-1:0][DATA_W-1:0] lane_rd;
  logic                         accept;

  assign accept = req_valid && !busy_q;

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      spad_bank_arb #(
        .LANES(LANES), .BANK_W(BANK_W), .WORD_W(WORD_W),
        .DATA_W(DATA_W), .BANK_ID(b)
      ) u_arb (
        .pending(pend_q), .lane_bank(bank_q), .lane_word(word_q),
        .lane_wdata(wdat_q), .served(served_bk[b]), .any(any_bk[b]),
        .sel_word(selw_bk[b]), .sel_wdata(seld_bk[b])
      );
      spad_bank_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .we(busy_q && write_q && any_bk[b]),
        .addr(selw_bk[b]), .wdata(seld_bk[b]), .rdata(rd_bk[b])
      );
    end
  endgenerate

  always_comb begin
    served_all = '0;
    for (int b = 0; b < BANKS; b++) served_all = served_all | served_bk[b];
    remain = pend_q & ~served_all;
    for (int l = 0; l < LANES; l++) lane_rd[l] = rd_bk[bank_q[l]];
  end

  // request decode
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      unused_off[l] = req_addr[l*ADDR_W +: OFF_W];
      bank_d[l]     = req_addr[l*ADDR_W + OFF_W +: BANK_W];
      word_d[l]     = req_addr[l*ADDR_W + OFF_W + BANK_W +: WORD_W];
      wdat_d[l]     = req_wdata[l*DATA_W +: DATA_W];
    end
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    deg_d  = deg_q;
    rdat_d = rdat_q;
    if (accept) begin
      busy_d = 1'b1;
      pend_d = req_mask;
      cnt_d  = '0;
      rdat_d = '0;
    end else if (busy_q) begin
      pend_d = remain;
      cnt_d  = cnt_q + CNT_W'(1);
      for (int l = 0; l < LANES; l++)
        if (served_all[l] && !write_q) rdat_d[l] = lane_rd[l];
      if (remain == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        deg_d  = cnt_q + CNT_W'(1);
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
      cnt_q  <= '0;
      deg_q  <= '0;
      rdat_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      deg_q  <= deg_d;
      rdat_q <= rdat_d;
    end
  end

  // request payload, loaded only on accept
  always_ff @(posedge clk) begin
    if (accept) begin
      write_q <= req_write;
      bank_q  <= bank_d;
      word_q  <= word_d;
      wdat_q  <= wdat_d;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign degree    = deg_q;
  assign rsp_rdata = rdat_q;

  // assertions
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q |=> !done_q);
  assert_progress_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_q && pend_q != '0) |=> ($countones(pend_q) < $past($countones(pend_q))));
  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy_q |=> ((pend_q & ~$past(pend_q)) == '0));
  assert_degree_range_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q |-> (deg_q >= CNT_W'(1) && deg_q <= CNT_W'(LANES)));
  assert_inactive_slot_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy_q |-> ((served_all & ~pend_q) == '0));
endmodule

// File: tb/sim_spad_banked.sv
`timescale 1ns/1ps
module sim_spad_banked;
  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [31:0]   req_mask;
  logic [383:0]  req_addr;
  logic [1023:0] req_wdata;
  logic          busy, done;
  logic [5:0]    degree;
  logic [1023:0] rsp_rdata;

  int unsigned tests = 0, fails = 0;
  bit          finished = 0;

  int unsigned ta [32];
  logic [31:0] td [32];
  logic [31:0] mdl [1024];

  always #5 clk = ~clk;

  spad_banked u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .degree(degree), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one request group, checked every clock against the model
  task automatic run(input bit wr, input logic [31:0] msk, input bit disturb, input string tag);
    int          deg;
    logic [31:0] exp_rd [32];
    deg = 0;
    for (int b = 0; b < 32; b++) begin
      int unsigned words [$];
      for (int l = 0; l < 32; l++) begin
        int unsigned w;
        w = (ta[l] >> 2) % 1024;
        if (msk[l] && ((w % 32) == b)) begin
          bit seen = 0;
          foreach (words[i]) if (words[i] == w) seen = 1;
          if (!seen) words.push_back(w);
        end
      end
      if (words.size() > deg) deg = words.size();
    end
    if (deg == 0) deg = 1;
    for (int l = 0; l < 32; l++)
      exp_rd[l] = (!wr && msk[l]) ? mdl[(ta[l] >> 2) % 1024] : 32'h0;
    if (wr) for (int l = 0; l < 32; l++) if (msk[l]) mdl[(ta[l] >> 2) % 1024] = td[l];

    req_valid = 1'b1;
    req_write = wr;
    req_mask  = msk;
    for (int l = 0; l < 32; l++) begin
      req_addr[l*12 +: 12]  = ta[l][11:0];
      req_wdata[l*32 +: 32] = td[l];
    end
    @(negedge clk);
    chk("R6", "busy after accept", busy, 1);
    chk("R6", "done after accept", done, 0);
    if (disturb) begin
      req_write = 1'b1;
      req_mask  = '1;
      req_addr  = '0;
      req_wdata = {32{32'hDEAD_BEEF}};
    end else req_valid = 1'b0;
    for (int k = 1; k <= deg; k++) begin
      @(negedge clk);
      chk(tag, "busy per cycle", busy, (k < deg));
      chk(tag, "done per cycle", done, (k == deg));
      if (k == deg) begin
        req_valid = 1'b0;
        chk(tag, "degree", degree, deg);
        for (int l = 0; l < 32; l++)
          chk(tag, $sformatf("rdata lane %0d", l), rsp_rdata[l*32 +: 32], exp_rd[l]);
      end
    end
    if (busy) begin
      while (busy) @(negedge clk);
      chk(tag, "busy too long", 1, 0);
    end
    @(negedge clk);
    chk("R6", "done is a pulse", done, 0);
    chk(disturb ? "R7" : "R6", "no new group", busy, 0);
  endtask

  task automatic set_stride(input int s, input int base, input int off);
    for (int l = 0; l < 32; l++) begin
      ta[l] = ((base + l*s) % 1024) * 4 + (off ? (l % 4) : 0);
      td[l] = 32'h0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_mask = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "busy", busy, 0);
    chk("R8", "done", done, 0);
    chk("R8", "degree", degree, 0);
    chk("R8", "rdata", (rsp_rdata == '0), 1);

    // fill every word, one row per group (distinct banks)
    for (int r = 0; r < 32; r++) begin
      for (int l = 0; l < 32; l++) begin
        ta[l] = (r*32 + l) * 4;
        td[l] = 32'h5A00_0000 ^ (r << 8) ^ l ^ (r * 32'h0001_3579);
      end
      run(1'b1, '1, 1'b0, "R1");
    end

    set_stride(1, 96, 0);  run(1'b0, '1, 1'b0, "R9");
    set_stride(1, 32, 1);  run(1'b0, '1, 1'b0, "R1");
    set_stride(2, 0, 0);   run(1'b0, '1, 1'b0, "R2");
    set_stride(4, 5, 0);   run(1'b0, '1, 1'b0, "R2");
    set_stride(8, 0, 0);   run(1'b0, '1, 1'b0, "R2");
    set_stride(32, 7, 0);  run(1'b0, '1, 1'b0, "R2");

    // broadcast: all lanes one word, then two words of one bank
    for (int l = 0; l < 32; l++) ta[l] = 200 * 4;
    run(1'b0, '1, 1'b0, "R3");
    for (int l = 0; l < 32; l++) ta[l] = (l < 16) ? 3*4 : (3 + 64)*4;
    run(1'b0, '1, 1'b0, "R3");

    // inactive lanes
    set_stride(32, 0, 0);  run(1'b0, 32'h0000_000F, 1'b0, "R5");
    set_stride(32, 0, 0);  run(1'b0, 32'h8000_0001, 1'b0, "R5");
    set_stride(1, 0, 0);   run(1'b0, 32'h0, 1'b0, "R10");

    // several writers to one word
    for (int l = 0; l < 32; l++) begin ta[l] = 300*4; td[l] = 32'h100 + l; end
    run(1'b1, '1, 1'b0, "R4");
    for (int l = 0; l < 32; l++) begin ta[l] = 301*4; td[l] = 32'h200 + l; end
    run(1'b1, 32'h00FF_0F00, 1'b0, "R4");
    set_stride(1, 288, 0); run(1'b0, '1, 1'b0, "R4");

    // masked write leaves other lanes' words alone
    for (int l = 0; l < 32; l++) begin ta[l] = (160 + l)*4; td[l] = 32'hC0DE_0000 + l; end
    run(1'b1, 32'h0000_FFFF, 1'b0, "R5");
    set_stride(1, 160, 0); run(1'b0, '1, 1'b0, "R5");

    // offers during busy are refused and write nothing
    set_stride(8, 1, 0);   run(1'b0, '1, 1'b1, "R7");
    set_stride(1, 0, 0);   run(1'b0, '1, 1'b0, "R7");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule